// File: doc/BRIEF.md
# Audio Sample Playback Controller

The block plays buffered audio through an 8-bit converter interface that has separate left and right sample outputs. Software or a DMA engine loads a 32-bit data word. The block unpacks that word into 8-bit channel samples at one of four selectable rates. Two formats are supported:

- 8-bit mono: four samples per word, each one sent to both channels.
- 16-bit stereo: two samples per word, with one byte for each channel and a swap bit that exchanges the channels.

The left and right converter updates are marked by two strobes that are never active together. After the last sample of a word has been taken, the block raises a maskable refill request. The request stays high until a new word is written. If no new word arrives in time, the block repeats the previous sample values and records an underrun.

Playback runs only while both the power bit and the converter-enable bit are set. Clearing either bit parks the rate divider and the byte pointer.

Top module: `audio_playback_ctrl`

## Requirements
- R1: After reset the control register and the data word are zero. Both sample outputs, both strobes, the refill request and the underrun flag are low.
- R2: A write with `wr_sel`=0 loads the control byte from `wr_data[7:0]`. The fields are:
  - bit 7: mono (1 = mono, 0 = stereo)
  - bit 6: request enable
  - bit 5: power
  - bit 4: converter enable
  - bit 3: channel swap
  - bits 2:1: rate
  - bit 0: ignored
- R3: The rate field selects the divider terminal count: 00 uses TC0, 01 uses TC1, 10 uses TC2 and 11 uses TC3. While playing, consecutive left strobes are TCn+1 clock cycles apart.
- R4: In mono mode a word yields four samples, least-significant byte first. Each sample appears unchanged on both `dac_left` and `dac_right`.
- R5: In stereo mode a word yields two 16-bit samples, bits 15:0 first. With swap=0 the low byte of each sample goes to the left output and the high byte to the right output.
- R6: In stereo mode with swap=1, the high byte goes to the left output and the low byte to the right output.
- R7: Each sample tick gives one cycle of `strobe_l`, with `dac_left` already holding the new value. It is followed in the next cycle by one cycle of `strobe_r`, with `dac_right` already holding the new value. The two strobes are never high in the same cycle.
- R8: `refill_req` is high while playback is running and the data word has been consumed (all of its samples have been taken) and not yet rewritten. A write with `wr_sel`=1 supplies the new word and lowers the request.
- R9: While the request-enable bit is 0, `refill_req` stays low.
- R10: While the power bit or the converter-enable bit is 0, no strobes occur and `refill_req` is low. On re-enable, playback restarts at byte 0 of the word.
- R11: A tick that needs a new word when none has been written is an underrun. Both strobes still occur, but both outputs repeat their last values and `underrun` goes high. The flag clears on the next data write.
- R12: A data write that lands in the same cycle as the tick taking a word's last sample counts as a refill. No request is raised, no underrun occurs, and the next tick plays byte 0 of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = control byte, 1 = data word |
| wr_data | input | 32 | Write data |
| dac_left | output | 8 | Left channel sample |
| dac_right | output | 8 | Right channel sample |
| strobe_l | output | 1 | Left update strobe |
| strobe_r | output | 1 | Right update strobe |
| refill_req | output | 1 | Request for a new data word |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Two functions can fall in the same cycle: a data write arriving and the tick that takes a word's last sample. A write on that tick must both refill the buffer and keep the request and the underrun flag low.

The bench provokes this collision by counting whole sample periods from an observed left strobe. It places the write exactly on the next tick edge. It then judges the outcome on three points: the request stays low, the underrun flag stays low, and the following tick plays byte 0 of the new word rather than a repeated value.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef struct packed {
    logic       mono;
    logic       req_en;
    logic       pwr;
    logic       dac_en;
    logic       swap;
    logic [1:0] rate;
  } apc_ctrl_t;

  // Number of the slot that finishes a word in the given format.
  function automatic logic slot_is_last(input logic mono, input logic [1:0] slot);
    return mono ? (slot == 2'd3) : (slot != 2'd0);
  endfunction

  // Returns {left, right} for the slot of a word.
  function automatic logic [15:0] slot_pair(input logic [31:0] word, input logic mono,
                                            input logic swap, input logic [1:0] slot);
    logic [7:0]  b;
    logic [15:0] h;
    b = word[slot*8 +: 8];
    h = word[slot[0]*16 +: 16];
    if (mono)      return {b, b};
    else if (swap) return {h[15:8], h[7:0]};
    else           return {h[7:0], h[15:8]};
  endfunction

endpackage

// File: rtl/apc_rate_gen.sv
module apc_rate_gen #(
  parameter int TC0 = 4,
  parameter int TC1 = 9,
  parameter int TC2 = 19,
  parameter int TC3 = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int TCA   = (TC0 > TC1) ? TC0 : TC1;
  localparam int TCB   = (TC2 > TC3) ? TC2 : TC3;
  localparam int TCMAX = (TCA > TCB) ? TCA : TCB;
  localparam int CW    = $clog2(TCMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (rate)
      2'd0:    limit = CW'(TC0);
      2'd1:    limit = CW'(TC1);
      2'd2:    limit = CW'(TC2);
      default: limit = CW'(TC3);
    endcase
  end

  assign tick = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/apc_unpacker.sv
module apc_unpacker
  import apc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick,
  input  logic        mono,
  input  logic        swap,
  input  logic        fresh,
  input  logic [31:0] word,
  output logic [7:0]  left_val,
  output logic [7:0]  right_val,
  output logic        under_evt,
  output logic        consume,
  output logic [1:0]  slot
);
  logic [15:0] pair;

  assign pair      = slot_pair(word, mono, swap, slot);
  assign left_val  = pair[15:8];
  assign right_val = pair[7:0];
  assign under_evt = tick && (slot == 2'd0) && !fresh;
  assign consume   = tick && !under_evt && slot_is_last(mono, slot);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)          slot <= 2'd0;
    else if (tick && !under_evt) slot <= consume ? 2'd0 : slot + 2'd1;
  end
endmodule

// File: rtl/apc_dac_stage.sv
module apc_dac_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       hold,
  input  logic [7:0] left_val,
  input  logic [7:0] right_val,
  output logic [7:0] dac_left,
  output logic [7:0] dac_right,
  output logic       strobe_l,
  output logic       strobe_r
);
  logic [7:0] right_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_left   <= 8'd0;
      dac_right  <= 8'd0;
      right_hold <= 8'd0;
      strobe_l   <= 1'b0;
      strobe_r   <= 1'b0;
    end else begin
      strobe_l <= run && tick;
      strobe_r <= run && strobe_l;
      if (run && tick && !hold) begin
        dac_left   <= left_val;
        right_hold <= right_val;
      end
      if (run && strobe_l) dac_right <= right_hold;
    end
  end
endmodule

// File: rtl/audio_playback_ctrl.sv
module audio_playback_ctrl
  import apc_pkg::*;
#(
  parameter int TC0 = 4,
  parameter int TC1 = 9,
  parameter int TC2 = 19,
  parameter int TC3 = 27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [7:0]  dac_left,
  output logic [7:0]  dac_right,
  output logic        strobe_l,
  output logic        strobe_r,
  output logic        refill_req,
  output logic        underrun
);
  apc_ctrl_t   ctrl;
  logic [31:0] data_q;
  logic        fresh;
  logic        run;
  logic        tick;
  logic        under_evt;
  logic        consume;
  logic [1:0]  slot;
  logic [7:0]  left_val;
  logic [7:0]  right_val;
  logic        ctrl_wr;
  logic        data_wr;

  assign ctrl_wr = wr_en && !wr_sel;
  assign data_wr = wr_en &&  wr_sel;
  assign run     = ctrl.pwr && ctrl.dac_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      data_q   <= '0;
      fresh    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= apc_ctrl_t'(wr_data[7:1]);
      if (data_wr) data_q <= wr_data;
      if (data_wr)      fresh <= 1'b1;
      else if (consume) fresh <= 1'b0;
      if (under_evt)    underrun <= 1'b1;
      else if (data_wr) underrun <= 1'b0;
    end
  end

  assign refill_req = run && ctrl.req_en && !fresh;

  apc_rate_gen #(.TC0(TC0), .TC1(TC1), .TC2(TC2), .TC3(TC3)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(ctrl.rate), .tick(tick)
  );

  apc_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .mono(ctrl.mono),
    .swap(ctrl.swap), .fresh(fresh), .word(data_q), .left_val(left_val),
    .right_val(right_val), .under_evt(under_evt), .consume(consume), .slot(slot)
  );

  apc_dac_stage u_dac (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .hold(under_evt),
    .left_val(left_val), .right_val(right_val), .dac_left(dac_left),
    .dac_right(dac_right), .strobe_l(strobe_l), .strobe_r(strobe_r)
  );
endmodule

// File: rtl/apc_checker.sv
module apc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_l,
  input logic       strobe_r,
  input logic       refill_req,
  input logic [7:0] dac_left,
  input logic [7:0] dac_right,
  input logic       run,
  input logic       req_en,
  input logic       mono,
  input logic       tick,
  input logic       under_evt,
  input logic [1:0] slot
);
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_l && strobe_r));

  p_tick_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> strobe_l);

  p_right_after_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_l |=> strobe_r);

  p_req_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |-> !refill_req);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!strobe_l && !strobe_r));

  p_idle_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (slot == 2'd0));

  p_underrun_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> $stable(dac_left));

  p_mono_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_r && $past(mono, 2) && !$past(under_evt, 2)) |-> (dac_right == dac_left));
endmodule

bind audio_playback_ctrl apc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_l(strobe_l), .strobe_r(strobe_r),
  .refill_req(refill_req), .dac_left(dac_left), .dac_right(dac_right),
  .run(run), .req_en(ctrl.req_en), .mono(ctrl.mono), .tick(tick),
  .under_evt(under_evt), .slot(slot)
);

// File: tb/tb_audio_playback_ctrl.sv
`timescale 1ns/1ps
module tb_audio_playback_ctrl;
  localparam int T0 = 4, T1 = 9, T2 = 19, T3 = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  dac_left, dac_right;
  logic        strobe_l, strobe_r, refill_req, underrun;

  int n_chk = 0;
  int n_bad = 0;
  longint cyc = 0;
  longint last_l = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_playback_ctrl #(.TC0(T0), .TC1(T1), .TC2(T2), .TC3(T3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dac_left(dac_left), .dac_right(dac_right), .strobe_l(strobe_l),
    .strobe_r(strobe_r), .refill_req(refill_req), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int period(input int rate);
    return (rate == 0 ? T0 : rate == 1 ? T1 : rate == 2 ? T2 : T3) + 1;
  endfunction

  // Expected {left,right} computed by shifting and dividing.
  function automatic logic [15:0] expect_pair(input logic [31:0] w, input bit mono,
                                              input bit swap, input int k);
    int b, lo, hi, h;
    if (mono) begin
      b = (w >> (8 * k)) % 256;
      return 16'(b * 257);
    end
    h  = (w >> (16 * k)) % 65536;
    lo = h % 256;
    hi = h / 256;
    return swap ? 16'(hi * 256 + lo) : 16'(lo * 256 + hi);
  endfunction

  // Waits for a left strobe, sampling at falling edges; checks spacing.
  task automatic wait_left(input int per, input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe_l && n < 300);
    check(strobe_l, "R7 strobe timeout", strobe_l, 1);
    if (last_l >= 0) check(cyc - last_l == per, req, cyc - last_l, per);
    last_l = cyc;
  endtask

  task automatic right_check(input logic [7:0] exp_r, input string req);
    @(negedge clk);
    check(strobe_r && !strobe_l, "R7 right strobe next cycle", {strobe_l, strobe_r}, 2'b01);
    check(dac_right == exp_r, req, dac_right, exp_r);
  endtask

  task automatic run_cfg(input int cfg);
    int   rate  = cfg % 4;
    bit   mono  = cfg[2];
    bit   swap  = cfg[3];
    bit   req   = cfg[4];
    int   per   = period(rate);
    int   slots = mono ? 4 : 2;
    logic [31:0] w [2];
    logic [15:0] p;
    logic [7:0]  ctl;
    string rq;
    w[0] = 32'hA5C3_1E70 ^ (cfg * 32'h0103_0507);
    w[1] = 32'h5B29_E4D6 ^ (cfg * 32'h0709_0B0D);
    rq   = mono ? "R4 mono" : (swap ? "R6 stereo swap" : "R5 stereo");
    ctl  = {mono, req, 1'b1, 1'b1, swap, 2'(rate), 1'b0};
    wr(1'b0, 32'(ctl & 8'hDF));
    wr(1'b1, w[0]);
    check(!underrun, "R11 flag cleared by data write", underrun, 0);
    last_l = -1;
    wr(1'b0, 32'(ctl));
    for (int n = 0; n < 2; n++) begin
      for (int k = 0; k < slots; k++) begin
        p = expect_pair(w[n], mono, swap, k);
        wait_left(per, "R3 tick spacing");
        check(dac_left == p[15:8], rq, dac_left, p[15:8]);
        right_check(p[7:0], rq);
        if (k == slots - 1)
          check(refill_req == req, req ? "R8 request after word" : "R9 request masked",
                refill_req, req);
        else
          check(!refill_req, "R8 no request mid-word", refill_req, 0);
      end
      if (n == 0) begin
        wr(1'b1, w[1]);
        check(!refill_req, "R8 request lowered by write", refill_req, 0);
      end
    end
    wait_left(per, "R3 tick spacing at underrun");
    check(dac_left == p[15:8], "R11 left repeated", dac_left, p[15:8]);
    check(underrun, "R11 underrun flag", underrun, 1);
    right_check(p[7:0], "R11 right repeated");
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] p;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({dac_left, dac_right, strobe_l, strobe_r, refill_req, underrun} == '0,
          "R1 reset state", {dac_left, dac_right, strobe_l, strobe_r, refill_req, underrun}, 0);

    // R10: power on, converter off; then converter on, power off.
    wr(1'b0, 32'hFFFF_FF00 | 32'b0110_0000);
    seen = 1'b0;
    repeat (80) begin
      @(negedge clk);
      if (strobe_l || strobe_r || refill_req) seen = 1'b1;
    end
    check(!seen, "R10 converter disabled quiet", seen, 0);
    wr(1'b0, 32'b0101_0000);
    seen = 1'b0;
    repeat (80) begin
      @(negedge clk);
      if (strobe_l || strobe_r || refill_req) seen = 1'b1;
    end
    check(!seen, "R10 power down quiet", seen, 0);

    // Exhaustive sweep of rate, format, swap and mask (R2..R9, R11).
    for (int c = 0; c < 32; c++) run_cfg(c);

    // R12: data write on the same edge as the last-slot tick (mono, rate 0).
    wr(1'b0, 32'b0011_0000);
    wr(1'b1, 32'h4433_2211);
    wr(1'b0, 32'b1111_0000);
    last_l = -1;
    for (int k = 0; k < 3; k++) wait_left(T0 + 1, "R3 tick spacing");
    repeat (T0) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h8877_6655;
    @(negedge clk);
    wr_en = 1'b0;
    check(strobe_l && dac_left == 8'h44, "R12 last slot played", dac_left, 8'h44);
    check(!refill_req, "R12 no request on collision", refill_req, 0);
    check(!underrun, "R12 no underrun on collision", underrun, 0);
    last_l = cyc;
    wait_left(T0 + 1, "R12 tick spacing");
    p = 16'h5555;
    check(dac_left == p[15:8] && !underrun, "R12 new word byte 0", dac_left, p[15:8]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule